// File: doc/BRIEF.md
# 8-bit Prescaled Timer with Compare-Clear

The block is an 8-bit up-counter. A divider drives it, and the divisor comes from a three-bit select field of a control byte. Software sets the timer up through a narrow write bus. That bus holds a control byte, a compare value, a two-bit interrupt mask, and a direct load of the counter. There are two counting modes. In the first the counter runs freely and wraps from 255 to 0. In the second it returns to zero on the tick after it equals the compare value. The second mode gives a periodic interrupt at f_clk / divisor / (compare + 1). Two event flags, one for compare match and one for overflow, stay set until their acknowledge input is pulsed. Each flag drives its interrupt request only when its mask bit is set.

A three-state machine holds the counting mode:
- ST_STOP: the counter holds.
- ST_FREE: the counter wraps freely.
- ST_CTC: the counter clears on compare.

Only a control write changes the state:
- go_stop: to ST_STOP when the select field is 000.
- go_ctc: to ST_CTC when the select field is non-zero and control bit 3 is 1.
- go_free: to ST_FREE when the select field is non-zero and control bit 3 is 0.

A control write also restarts the divider. This places the first increment exactly one divisor period after the write.

Top module: `tmr8_top`

## Requirements
- R1: After reset, the counter is 0, both flags are 0, both interrupt requests are 0, and the timer is stopped.
- R2: Control bits 2:0 select the tick rate:
  - 000 stops the counter.
  - 001, 010, 011, 100, 101, 110 and 111 divide the clock by 1, 8, 32, 64, 128, 256 and 1024.

  The first increment lands the divisor's number of cycles after the control write, and each later increment follows the same number of cycles after the one before.
- R3: With control bit 3 at 0, the counter wraps from 255 to 0, and on that tick the overflow flag sets.
- R4: With control bit 3 at 1, the counter goes to 0 on the tick after it equals the compare value, giving a period of compare + 1 ticks. In this mode the overflow flag never sets, even when the compare value is 255.
- R5: On any tick where the counter equals the compare value, the compare flag sets. This holds in both modes, and in the free mode the counter keeps counting.
- R6: The compare request is the compare flag gated by mask bit 1. The overflow request is the overflow flag gated by mask bit 0.
- R7: A flag stays set until its acknowledge input is high at a clock edge. If a new event occurs in the same cycle, the set wins.
- R8: Control bit 7 (force-compare strobe) and control bits 5:4 (output mode) have no effect on the counter or the flags.
- R9: Write addresses are 0 = control, 1 = compare, 2 = mask, 3 = counter. A counter write takes effect at the next edge and overrides that cycle's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| ack_cmp | input | 1 | Clears the compare flag |
| ack_ovf | input | 1 | Clears the overflow flag |
| count | output | 8 | Current counter value |
| cmp_flag | output | 1 | Compare-match event flag |
| ovf_flag | output | 1 | Overflow event flag |
| irq_cmp | output | 1 | Masked compare interrupt request |
| irq_ovf | output | 1 | Masked overflow interrupt request |

## Verification
The hardest cases to reach from the ports are the wrap from 255 under the slow divisors and the compare-clear at 255. By counting alone, these take hundreds of thousands of cycles. The stimulus first stops the timer. It then loads the counter close to the boundary through the counter address, and only after that writes the control byte. Because the control write restarts the divider, every tick lands at a known cycle. Each expected value is therefore a plain count of divisor periods since the write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_FREE = 2'd1,
        ST_CTC  = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;

    // log2 of the divisor chosen by the select field
    function automatic int sel_log2(input logic [2:0] sel);
        case (sel)
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PW-1:0] pres_q;
    logic [PW-1:0] lim;
    logic          run;

    assign run = (sel != 3'd0);

    // low-order ones mask: divisor minus one
    generate
        for (genvar gi = 0; gi < PW; gi++) begin : g_lim
            assign lim[gi] = (gi < sel_log2(sel));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
        end else if (restart || !run) begin
            pres_q <= '0;
        end else begin
            pres_q <= pres_q + 1'b1;
        end
    end

    assign tick = run && ((pres_q & lim) == lim);

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_sel,
    input  logic         cfg_ctc,
    input  logic         tick,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    input  logic         ack_cmp,
    input  logic         ack_ovf,
    output logic [W-1:0] cnt,
    output logic         cmp_flag,
    output logic         ovf_flag,
    output tmr_state_e   state
);

    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    tmr_state_e   state_q, state_nx;
    logic [W-1:0] cnt_q, cnt_nx;
    logic         hit, wrap;
    logic         cmp_q, ovf_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions go_stop / go_ctc / go_free on control writes only
    always_comb begin
        state_nx = state_q;
        if (cfg_we) begin
            if (cfg_sel == 3'd0) begin
                state_nx = ST_STOP;
            end else if (cfg_ctc) begin
                state_nx = ST_CTC;
            end else begin
                state_nx = ST_FREE;
            end
        end
    end

    // per-state counting behaviour
    always_comb begin
        cnt_nx = cnt_q;
        hit    = 1'b0;
        wrap   = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                cnt_nx = cnt_q;
            end
            ST_FREE: begin
                if (tick) begin
                    hit    = (cnt_q == cmp_val);
                    wrap   = (cnt_q == CNT_TOP);
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            ST_CTC: begin
                if (tick) begin
                    hit    = (cnt_q == cmp_val);
                    cnt_nx = hit ? '0 : cnt_q + 1'b1;
                end
            end
            default: begin
                cnt_nx = cnt_q;
            end
        endcase
        if (load_we) begin
            cnt_nx = load_val;
            hit    = 1'b0;
            wrap   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            if (hit) begin
                cmp_q <= 1'b1;
            end else if (ack_cmp) begin
                cmp_q <= 1'b0;
            end
            if (wrap) begin
                ovf_q <= 1'b1;
            end else if (ack_ovf) begin
                ovf_q <= 1'b0;
            end
        end
    end

    assign cnt      = cnt_q;
    assign cmp_flag = cmp_q;
    assign ovf_flag = ovf_q;
    assign state    = state_q;

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
    import tmr8_pkg::*;
#(
    parameter int W  = 8,
    parameter int PW = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic         ack_cmp,
    input  logic         ack_ovf,
    output logic [W-1:0] count,
    output logic         cmp_flag,
    output logic         ovf_flag,
    output logic         irq_cmp,
    output logic         irq_ovf
);

    logic         ctrl_we, cmp_we, mask_we, cnt_we;
    logic [2:0]   sel_q;
    logic         ctc_q;
    logic [W-1:0] cmp_q;
    logic [1:0]   mask_q;
    logic         pre_tick;
    tmr_state_e   core_state;

    assign ctrl_we = bus_we && (bus_addr == ADDR_CTRL);
    assign cmp_we  = bus_we && (bus_addr == ADDR_CMP);
    assign mask_we = bus_we && (bus_addr == ADDR_MASK);
    assign cnt_we  = bus_we && (bus_addr == ADDR_CNT);

    // control byte: only the select field and the mode bit are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 3'd0;
            ctc_q  <= 1'b0;
            cmp_q  <= '0;
            mask_q <= 2'b00;
        end else begin
            if (ctrl_we) begin
                sel_q <= bus_wdata[2:0];
                ctc_q <= bus_wdata[3];
            end
            if (cmp_we) begin
                cmp_q <= bus_wdata;
            end
            if (mask_we) begin
                mask_q <= bus_wdata[1:0];
            end
        end
    end

    tmr8_prescaler #(.PW(PW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_we),
        .sel     (sel_q),
        .tick    (pre_tick)
    );

    tmr8_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (ctrl_we),
        .cfg_sel  (bus_wdata[2:0]),
        .cfg_ctc  (bus_wdata[3]),
        .tick     (pre_tick),
        .load_we  (cnt_we),
        .load_val (bus_wdata),
        .cmp_val  (cmp_q),
        .ack_cmp  (ack_cmp),
        .ack_ovf  (ack_ovf),
        .cnt      (count),
        .cmp_flag (cmp_flag),
        .ovf_flag (ovf_flag),
        .state    (core_state)
    );

    assign irq_cmp = cmp_flag && mask_q[1];
    assign irq_ovf = ovf_flag && mask_q[0];

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_we,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp_val,
    input logic         tick,
    input tmr_state_e   state,
    input logic         cmp_flag,
    input logic         ovf_flag,
    input logic         ack_cmp,
    input logic         ack_ovf,
    input logic         irq_cmp,
    input logic         irq_ovf
);

    a_r2_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !bus_we) |=> $stable(cnt));

    a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt == '0));

    a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTC && tick && cnt == cmp_val && !bus_we) |=> (cnt == '0));

    a_r4_ctc_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTC && !bus_we && !ovf_flag) |=> !ovf_flag);

    a_r5_cmp_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> ($past(cnt) == $past(cmp_val)));

    a_r6_irq_cmp_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp |-> cmp_flag);

    a_r6_irq_ovf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> ovf_flag);

    a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !ack_cmp) |=> cmp_flag);

    a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ack_ovf) |=> ovf_flag);

endmodule

bind tmr8_top tmr8_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .cnt      (count),
    .cmp_val  (cmp_q),
    .tick     (pre_tick),
    .state    (core_state),
    .cmp_flag (cmp_flag),
    .ovf_flag (ovf_flag),
    .ack_cmp  (ack_cmp),
    .ack_ovf  (ack_ovf),
    .irq_cmp  (irq_cmp),
    .irq_ovf  (irq_ovf)
);

// File: tb/tmr8_top_tb.sv
module tmr8_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {ctrl[47:40], cmp[39:32], preload[31:24], wait[23:8], expected count[7:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h01, 8'd200, 8'd10,  16'd20,   8'd30},
        {8'h02, 8'd200, 8'd0,   16'd41,   8'd5},
        {8'h03, 8'd200, 8'd0,   16'd100,  8'd3},
        {8'h04, 8'd200, 8'd0,   16'd200,  8'd3},
        {8'h05, 8'd200, 8'd0,   16'd300,  8'd2},
        {8'h06, 8'd200, 8'd0,   16'd600,  8'd2},
        {8'h07, 8'd200, 8'd0,   16'd3000, 8'd2},
        {8'h00, 8'd200, 8'd77,  16'd50,   8'd77},
        {8'h09, 8'd4,   8'd0,   16'd12,   8'd2},
        {8'h0A, 8'd9,   8'd3,   16'd100,  8'd5},
        {8'h31, 8'd200, 8'd250, 16'd10,   8'd4},
        {8'h09, 8'd255, 8'd250, 16'd10,   8'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       ack_cmp = 1'b0;
    logic       ack_ovf = 1'b0;
    logic [7:0] count;
    logic       cmp_flag, ovf_flag, irq_cmp, irq_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr8_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ack_cmp   (ack_cmp),
        .ack_ovf   (ack_ovf),
        .count     (count),
        .cmp_flag  (cmp_flag),
        .ovf_flag  (ovf_flag),
        .irq_cmp   (irq_cmp),
        .irq_ovf   (irq_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ack_both();
        @(negedge clk);
        ack_cmp = 1'b1; ack_ovf = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_cmp = 1'b0; ack_ovf = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [7:0] ctrl, input logic [7:0] cmpv, input logic [7:0] pre);
        wr(2'd0, 8'h00);
        ack_both();
        wr(2'd1, cmpv);
        wr(2'd3, pre);
        wr(2'd0, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 cmp_flag", cmp_flag, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 irqs", {irq_cmp, irq_ovf}, 0);
        step(5);
        chk("R1 stopped", count, 0);

        // vector table: R2 rates, R4 clear period, R8 output mode bits ignored
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 8'h00);
            wr(2'd1, VEC[i][39:32]);
            wr(2'd3, VEC[i][31:24]);
            wr(2'd0, VEC[i][47:40]);
            step(int'(VEC[i][23:8]));
            chk(VEC[i][43] ? "R4 vector" : "R2 vector", count, int'(VEC[i][7:0]));
        end

        // R3 overflow, R6 masking, R7 hold and acknowledge
        wr(2'd2, 8'h00);
        setup(8'h01, 8'd100, 8'd254);
        step(1);
        chk("R3 at 255", count, 255);
        chk("R3 no flag yet", ovf_flag, 0);
        step(1);
        chk("R3 wrap count", count, 0);
        chk("R3 flag set", ovf_flag, 1);
        chk("R6 ovf masked", irq_ovf, 0);
        wr(2'd2, 8'h01);
        chk("R6 ovf unmasked", irq_ovf, 1);
        chk("R6 cmp stays masked", irq_cmp, 0);
        wr(2'd0, 8'h00);
        step(4);
        chk("R7 flag held", ovf_flag, 1);
        ack_both();
        chk("R7 flag cleared", ovf_flag, 0);
        chk("R7 irq cleared", irq_ovf, 0);

        // R4 clear-on-match, R5 compare flag, R6 compare mask
        wr(2'd2, 8'h02);
        setup(8'h09, 8'd4, 8'd0);
        step(4);
        chk("R4 at compare", count, 4);
        chk("R5 flag before match tick", cmp_flag, 0);
        step(1);
        chk("R4 cleared", count, 0);
        chk("R5 flag set", cmp_flag, 1);
        chk("R6 cmp irq", irq_cmp, 1);
        step(5);
        chk("R4 period", count, 0);

        // R4 no overflow in clear mode at compare 255
        setup(8'h09, 8'd255, 8'd250);
        step(6);
        chk("R4 wrap to 0", count, 0);
        chk("R4 no ovf flag", ovf_flag, 0);
        chk("R5 flag at 255", cmp_flag, 1);

        // R5 free mode keeps counting past the match
        setup(8'h01, 8'd3, 8'd0);
        step(3);
        chk("R5 no flag yet", cmp_flag, 0);
        step(1);
        chk("R5 free count", count, 4);
        chk("R5 free flag", cmp_flag, 1);

        // R8 force strobe and output mode bits have no effect
        setup(8'hB0, 8'd5, 8'd5);
        step(3);
        chk("R8 count", count, 5);
        chk("R8 cmp_flag", cmp_flag, 0);
        chk("R8 ovf_flag", ovf_flag, 0);

        // R9 counter write overrides a running tick
        setup(8'h01, 8'd200, 8'd10);
        step(3);
        wr(2'd3, 8'd100);
        chk("R9 load", count, 100);
        step(2);
        chk("R9 resumes", count, 102);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule